// File: doc/BRIEF.md
# Step Pulse Generator with Selectable Output Encoding

This block turns a signed velocity value written by a host into motion steps on two output pins. Each clock the velocity is added into a phase accumulator. A carry out of the accumulator is a forward step and a borrow out is a reverse step. A small sequencer then encodes every step on the two pins in one of three formats: step plus direction, separate up and down pulses, or a two-bit Gray code. Programmable pulse length, pulse spacing and direction setup times shape the pulses, so the outputs can drive external power stages directly.

The block also presents each pin to a pin driver. For each pin it gives a data level, a drive enable and an ownership flag. The ownership flag tells the pin driver to hand the pad to this block while it is active. Each pin has its own polarity bit and open-collector bit, and both are held in the generator's own control register. When open-collector drive is chosen, the block drives a low level and releases a high level. A signed running step count can be read back as position feedback.

Top module: `motion_pulse_gen`

## Requirements
- R1: The signed rate (register 0, low ACC_W bits, two's complement) is added each clock into an ACC_W-bit unsigned accumulator. A carry out gives a forward step and a borrow out gives a reverse step. A rate of zero gives no steps.
- R2: When the enable bit (control bit 2) is 0 or the mode is off, no steps are counted and every bit of pin data, drive enable and ownership is 0.
- R3: In mode 1 (step/direction), pin A pulses high once per step. Pin B is 1 for reverse and 0 for forward.
- R4: The timing register holds the pulse length in bits 7:0, the space in bits 15:8 and the setup in bits 23:16. A programmed value of 0 acts as 1. A step pulse is high for exactly the pulse length, in clocks. It is low for at least the space count between pulses. A direction change comes at least the setup count of clocks before the next rising step edge.
- R5: In mode 2 (up/down), a forward step pulses pin A and a reverse step pulses pin B, with the R4 length and space. The two pins are never high together.
- R6: In mode 3 (quadrature), each step moves the pair {A,B} one place along 00, 01, 11, 10 (forward) or backward along it (reverse). Exactly one pin changes per step. Changes are at least the space count apart. The sequence starts again at 00 after the block is disabled.
- R7: The ownership output of both pins is 1 while the block is enabled with a mode other than off.
- R8: Control bits 19 and 20 invert the data level of pins A and B while the block is active.
- R9: Control bits 21 and 22 select open-collector drive for pins A and B. With open-collector drive, the drive enable is 1 when the pin level is low and 0 when it is high. Without it, the drive enable is 1 whenever the block is active.
- R10: The read port returns a signed 32-bit step count. It changes by +1 or -1 for each step emitted and is kept while the block is disabled.
- R11: Host writes use wr_addr 0 for rate, 1 for timing and 2 for control. Control bits 1:0 select the mode: 0 off, 1 step/direction, 2 up/down, 3 quadrature.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 2 | Host register select |
| wr_data | input | 32 | Host write data |
| rd_data | output | 32 | Signed step count |
| pin_data | output | 2 | Data level for pin A (bit 0) and pin B (bit 1) |
| pin_oe | output | 2 | Drive enable per pin |
| pin_own | output | 2 | Pin ownership request per pin |

## Verification
The main function is run in each output mode with positive and negative rates of different sizes, and with pulse, space and setup counts ranging from zero to several clocks. Positive and negative rates separate carry from borrow handling and show whether pin B, the choice of up/down pin and the Gray direction follow the sign. Comparing edge counts on the pins with the readback change shows whether steps are lost or counted twice. Measured widths and gaps separate correct phase timing from phases that are one clock off, and the zero-valued timing case shows the value-zero-means-one rule. Directed cases then go through disable, mode off, polarity and open-collector combinations, and check that the quadrature sequence starts again after a disable.

// File: rtl/mpg_pkg.sv
package mpg_pkg;

   typedef enum logic [1:0] {
      MODE_OFF     = 2'd0,
      MODE_STEPDIR = 2'd1,
      MODE_UPDOWN  = 2'd2,
      MODE_QUAD    = 2'd3
   } mpg_mode_e;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_SETUP,
      SQ_PULSE,
      SQ_SPACE
   } mpg_seq_e;

   localparam logic [1:0] ADDR_RATE   = 2'd0;
   localparam logic [1:0] ADDR_TIMING = 2'd1;
   localparam logic [1:0] ADDR_CTRL   = 2'd2;

   localparam int CTRL_EN_BIT  = 2;
   localparam int CTRL_INV_LSB = 19;
   localparam int CTRL_OC_LSB  = 21;

endpackage

// File: rtl/mpg_rate_acc.sv
module mpg_rate_acc
   import mpg_pkg::*;
#(
   parameter int ACC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic [ACC_W-1:0] rate,
   input  logic             take,
   output logic             pend,
   output logic             pend_rev
);

   localparam int SUM_W = ACC_W + 1;

   logic [ACC_W-1:0] acc_q;
   logic [SUM_W-1:0] sum;

   // sign-extended add; the extra bit is set on carry (rate >= 0) or borrow (rate < 0)
   always_comb sum = {1'b0, acc_q} + {rate[ACC_W-1], rate};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q    <= '0;
         pend     <= 1'b0;
         pend_rev <= 1'b0;
      end else if (!active) begin
         acc_q    <= '0;
         pend     <= 1'b0;
         pend_rev <= 1'b0;
      end else if (pend) begin
         if (take) pend <= 1'b0;
      end else begin
         acc_q <= sum[ACC_W-1:0];
         if (sum[SUM_W-1]) begin
            pend     <= 1'b1;
            pend_rev <= rate[ACC_W-1];
         end
      end
   end

endmodule

// File: rtl/mpg_sequencer.sv
module mpg_sequencer
   import mpg_pkg::*;
#(
   parameter int TIME_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  mpg_mode_e         mode,
   input  logic              pend,
   input  logic              pend_rev,
   input  logic [TIME_W-1:0] len,
   input  logic [TIME_W-1:0] space,
   input  logic [TIME_W-1:0] setup,
   output logic              take,
   output logic [1:0]        raw
);

   mpg_seq_e          state_q;
   logic [TIME_W-1:0] cnt_q;
   logic              a_q, b_q, dir_q;
   logic [1:0]        ph_q;

   // a programmed zero behaves as one clock
   function automatic logic [TIME_W-1:0] load_of(input logic [TIME_W-1:0] v);
      return (v == '0) ? '0 : v - 1'b1;
   endfunction

   assign take = active && pend && (state_q == SQ_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         cnt_q   <= '0;
         a_q     <= 1'b0;
         b_q     <= 1'b0;
         dir_q   <= 1'b0;
         ph_q    <= 2'd0;
      end else if (!active) begin
         state_q <= SQ_IDLE;
         cnt_q   <= '0;
         a_q     <= 1'b0;
         b_q     <= 1'b0;
         dir_q   <= 1'b0;
         ph_q    <= 2'd0;
      end else begin
         unique case (state_q)
            SQ_IDLE: begin
               if (pend) begin
                  unique case (mode)
                     MODE_STEPDIR: begin
                        if (pend_rev != dir_q) begin
                           dir_q   <= pend_rev;
                           state_q <= SQ_SETUP;
                           cnt_q   <= load_of(setup);
                        end else begin
                           a_q     <= 1'b1;
                           state_q <= SQ_PULSE;
                           cnt_q   <= load_of(len);
                        end
                     end
                     MODE_UPDOWN: begin
                        if (pend_rev) b_q <= 1'b1;
                        else          a_q <= 1'b1;
                        state_q <= SQ_PULSE;
                        cnt_q   <= load_of(len);
                     end
                     default: begin
                        ph_q    <= ph_q + (pend_rev ? 2'b11 : 2'b01);
                        state_q <= SQ_SPACE;
                        cnt_q   <= load_of(space);
                     end
                  endcase
               end
            end
            SQ_SETUP: begin
               if (cnt_q == '0) begin
                  a_q     <= 1'b1;
                  state_q <= SQ_PULSE;
                  cnt_q   <= load_of(len);
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            SQ_PULSE: begin
               if (cnt_q == '0) begin
                  a_q     <= 1'b0;
                  b_q     <= 1'b0;
                  state_q <= SQ_SPACE;
                  cnt_q   <= load_of(space);
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            default: begin
               if (cnt_q == '0) state_q <= SQ_IDLE;
               else             cnt_q   <= cnt_q - 1'b1;
            end
         endcase
      end
   end

   always_comb begin
      unique case (mode)
         MODE_STEPDIR: raw = {dir_q, a_q};
         MODE_UPDOWN:  raw = {b_q, a_q};
         MODE_QUAD:    raw = {ph_q[1] ^ ph_q[0], ph_q[1]};
         default:      raw = 2'b00;
      endcase
   end

endmodule

// File: rtl/mpg_pin_stage.sv
module mpg_pin_stage (
   input  logic active,
   input  logic raw,
   input  logic inv,
   input  logic oc,
   output logic data,
   output logic oe,
   output logic own
);

   logic lvl;

   always_comb begin
      lvl  = raw ^ inv;
      data = active & lvl;
      oe   = active & (oc ? ~lvl : 1'b1);
      own  = active;
   end

endmodule

// File: rtl/motion_pulse_gen.sv
module motion_pulse_gen
   import mpg_pkg::*;
#(
   parameter int ACC_W  = 16,
   parameter int TIME_W = 8,
   parameter int POS_W  = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [1:0]  wr_addr,
   input  logic [31:0] wr_data,
   output logic [31:0] rd_data,
   output logic [1:0]  pin_data,
   output logic [1:0]  pin_oe,
   output logic [1:0]  pin_own
);

   localparam int NPIN    = 2;
   localparam int SPACE_L = TIME_W;
   localparam int SETUP_L = 2 * TIME_W;

   if (ACC_W < 4 || ACC_W > 32) begin : g_bad_acc
      $error("motion_pulse_gen: ACC_W out of range");
   end
   if (TIME_W < 1 || 3 * TIME_W > 32) begin : g_bad_time
      $error("motion_pulse_gen: TIME_W out of range");
   end
   if (POS_W < 2 || POS_W > 32) begin : g_bad_pos
      $error("motion_pulse_gen: POS_W out of range");
   end

   logic [ACC_W-1:0]  rate_q;
   logic [TIME_W-1:0] len_q, space_q, setup_q;
   mpg_mode_e         mode_q;
   logic              en_q;
   logic [NPIN-1:0]   inv_q, oc_q;
   logic [POS_W-1:0]  count_q;

   logic       active;
   logic       pend, pend_rev, take;
   logic [1:0] raw;

   assign active = en_q && (mode_q != MODE_OFF);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rate_q  <= '0;
         len_q   <= '0;
         space_q <= '0;
         setup_q <= '0;
         mode_q  <= MODE_OFF;
         en_q    <= 1'b0;
         inv_q   <= '0;
         oc_q    <= '0;
      end else if (wr_en) begin
         unique case (wr_addr)
            ADDR_RATE: rate_q <= wr_data[ACC_W-1:0];
            ADDR_TIMING: begin
               len_q   <= wr_data[TIME_W-1:0];
               space_q <= wr_data[SPACE_L +: TIME_W];
               setup_q <= wr_data[SETUP_L +: TIME_W];
            end
            ADDR_CTRL: begin
               mode_q <= mpg_mode_e'(wr_data[1:0]);
               en_q   <= wr_data[CTRL_EN_BIT];
               inv_q  <= wr_data[CTRL_INV_LSB +: NPIN];
               oc_q   <= wr_data[CTRL_OC_LSB +: NPIN];
            end
            default: ;
         endcase
      end
   end

   mpg_rate_acc #(.ACC_W(ACC_W)) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (active),
      .rate     (rate_q),
      .take     (take),
      .pend     (pend),
      .pend_rev (pend_rev)
   );

   mpg_sequencer #(.TIME_W(TIME_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (active),
      .mode     (mode_q),
      .pend     (pend),
      .pend_rev (pend_rev),
      .len      (len_q),
      .space    (space_q),
      .setup    (setup_q),
      .take     (take),
      .raw      (raw)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count_q <= '0;
      else if (take)
         count_q <= count_q + (pend_rev ? {POS_W{1'b1}} : POS_W'(1));
   end

   if (POS_W == 32) begin : g_rd_full
      assign rd_data = count_q;
   end else begin : g_rd_ext
      assign rd_data = {{(32 - POS_W){count_q[POS_W-1]}}, count_q};
   end

   for (genvar i = 0; i < NPIN; i++) begin : g_pin
      mpg_pin_stage u_pin (
         .active (active),
         .raw    (raw[i]),
         .inv    (inv_q[i]),
         .oc     (oc_q[i]),
         .data   (pin_data[i]),
         .oe     (pin_oe[i]),
         .own    (pin_own[i])
      );
   end

endmodule

// File: rtl/mpg_checker.sv
module mpg_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        active,
   input logic [1:0]  mode,
   input logic [1:0]  raw,
   input logic [1:0]  pin_data,
   input logic [1:0]  pin_oe,
   input logic [1:0]  pin_own,
   input logic [31:0] count
);

   p_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> (pin_data == 2'b00 && pin_oe == 2'b00 && pin_own == 2'b00));

   p_own_gates_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_own == 2'b00) |-> (pin_data == 2'b00 && pin_oe == 2'b00));

   p_dir_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (active && $past(active) && mode == 2'd1 && $past(mode) == 2'd1 && raw[1] != $past(raw[1]))
         |-> (!raw[0] && !$past(raw[0])));

   p_updown_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (active && mode == 2'd2) |-> !(raw[0] && raw[1]));

   p_gray_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (active && $past(active) && mode == 2'd3 && $past(mode) == 2'd3)
         |-> ($countones(raw ^ $past(raw)) <= 1));

   p_count_unit_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (count != $past(count))
         |-> (count == $past(count) + 32'd1 || count == $past(count) - 32'd1));

endmodule

bind motion_pulse_gen mpg_checker u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .active   (active),
   .mode     (mode_q),
   .raw      (raw),
   .pin_data (pin_data),
   .pin_oe   (pin_oe),
   .pin_own  (pin_own),
   .count    (rd_data)
);

// File: tb/motion_pulse_gen_tb_top.sv
module motion_pulse_gen_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = 2'd0;
   logic [31:0] wr_data = 32'd0;
   logic [31:0] rd_data;
   logic [1:0]  pin_data, pin_oe, pin_own;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   motion_pulse_gen dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .rd_data  (rd_data),
      .pin_data (pin_data),
      .pin_oe   (pin_oe),
      .pin_own  (pin_own)
   );

   // vector: {mode[7:0], rate[15:0], len[7:0], space[7:0], setup[7:0], window[15:0]}
   localparam int NV = 7;
   localparam logic [63:0] VEC [NV] = '{
      {8'd1, 16'h2000, 8'd3, 8'd2, 8'd4, 16'd400},
      {8'd1, 16'hD000, 8'd2, 8'd3, 8'd5, 16'd400},
      {8'd2, 16'h4000, 8'd2, 8'd2, 8'd0, 16'd300},
      {8'd2, 16'hE800, 8'd4, 8'd1, 8'd0, 16'd300},
      {8'd3, 16'h5000, 8'd0, 8'd3, 8'd0, 16'd300},
      {8'd3, 16'h9000, 8'd0, 8'd2, 8'd0, 16'd300},
      {8'd1, 16'h7FFF, 8'd0, 8'd0, 8'd0, 16'd200}
   };

   // pin monitor, sampled on the falling edge
   bit         mon_on = 1'b0;
   int         cyc = 0;
   logic [1:0] prev;
   int rise_a, rise_b, trans, simul;
   int hi_a, hi_b, lo_a, hi_min, hi_max, lo_min;
   int last_chg, int_min, last_bchg, gap_min;
   bit have_chg, bchg_pend, seen_fall;

   task automatic mon_start();
      prev = pin_data;
      rise_a = 0; rise_b = 0; trans = 0; simul = 0;
      hi_a = 0; hi_b = 0; lo_a = 0;
      hi_min = 1 << 30; hi_max = 0; lo_min = 1 << 30;
      int_min = 1 << 30; gap_min = 1 << 30;
      have_chg = 1'b0; bchg_pend = 1'b0; seen_fall = 1'b0;
      mon_on = 1'b1;
   endtask

   always @(negedge clk) begin
      cyc++;
      if (mon_on) begin
         if (pin_data != prev) begin
            if (have_chg && (cyc - last_chg) < int_min) int_min = cyc - last_chg;
            have_chg = 1'b1;
            last_chg = cyc;
            trans += int'(pin_data[0] != prev[0]) + int'(pin_data[1] != prev[1]);
            if (pin_data[0] != prev[0] && pin_data[1] != prev[1]) simul++;
         end
         if (pin_data[1] != prev[1]) begin
            last_bchg = cyc;
            bchg_pend = 1'b1;
         end
         if (pin_data[0] && !prev[0]) begin
            rise_a++;
            if (bchg_pend) begin
               if ((cyc - last_bchg) < gap_min) gap_min = cyc - last_bchg;
               bchg_pend = 1'b0;
            end
            if (seen_fall && lo_a < lo_min) lo_min = lo_a;
            lo_a = 0;
         end
         if (pin_data[1] && !prev[1]) rise_b++;
         if (!pin_data[0] && prev[0]) begin
            if (hi_a < hi_min) hi_min = hi_a;
            if (hi_a > hi_max) hi_max = hi_a;
            hi_a = 0;
            seen_fall = 1'b1;
         end
         if (!pin_data[1] && prev[1] && hi_b > 0) begin
            if (hi_b < hi_min) hi_min = hi_b;
            if (hi_b > hi_max) hi_max = hi_b;
            hi_b = 0;
         end
         if (pin_data[0]) hi_a++;
         else             lo_a++;
         if (pin_data[1]) hi_b++;
         prev = pin_data;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   function automatic logic [31:0] ctrl(input int mode, input bit en,
                                        input logic [1:0] inv, input logic [1:0] oc);
      return 32'(mode & 3) | (32'(en) << 2) | (32'(inv) << 19) | (32'(oc) << 21);
   endfunction

   task automatic finish_run();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         finish_run();
      end
   end

   initial begin
      int c0, delta, mag;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      chk(pin_data == 2'b00, "R2 reset data", int'(pin_data), 0);
      chk(pin_own == 2'b00, "R7 reset own", int'(pin_own), 0);
      chk(rd_data == 32'd0, "R10 reset count", int'(rd_data), 0);

      // table of mode/rate/timing vectors
      for (int v = 0; v < NV; v++) begin
         int mode, ln, sp, su, win, lnx, spx, sux;
         logic [15:0] rt;
         mode = int'(VEC[v][63:56]);
         rt   = VEC[v][55:40];
         ln   = int'(VEC[v][39:32]);
         sp   = int'(VEC[v][31:24]);
         su   = int'(VEC[v][23:16]);
         win  = int'(VEC[v][15:0]);
         lnx  = (ln == 0) ? 1 : ln;
         spx  = (sp == 0) ? 1 : sp;
         sux  = (su == 0) ? 1 : su;
         wr(2'd2, ctrl(mode, 1'b0, 2'b00, 2'b00));
         wr(2'd1, {8'd0, 8'(su), 8'(sp), 8'(ln)});
         wr(2'd0, {{16{rt[15]}}, rt});
         c0 = $signed(rd_data);
         mon_start();
         wr(2'd2, ctrl(mode, 1'b1, 2'b00, 2'b00));
         repeat (win) @(negedge clk);
         wr(2'd0, 32'd0);
         repeat (400) @(negedge clk);
         delta = $signed(rd_data) - c0;
         mag   = (delta < 0) ? -delta : delta;
         mon_on = 1'b0;

         // R1: carry/borrow gives steps in the sign's direction
         chk(rt[15] ? (delta < 0) : (delta > 0), "R1 step direction", delta, rt[15] ? -1 : 1);
         if (mode == 1) begin
            chk(rise_a == mag, "R3 one step pulse per count", rise_a, mag);
            chk(pin_data[1] == rt[15], "R3 direction level", int'(pin_data[1]), int'(rt[15]));
            chk(hi_min == lnx && hi_max == lnx, "R4 pulse length", hi_max, lnx);
            chk(lo_min >= spx, "R4 space", lo_min, spx);
            chk(gap_min >= sux, "R4 direction setup", gap_min, sux);
         end else if (mode == 2) begin
            chk((rt[15] ? rise_b : rise_a) == mag, "R5 active pin pulses", rt[15] ? rise_b : rise_a, mag);
            chk((rt[15] ? rise_a : rise_b) == 0, "R5 idle pin quiet", rt[15] ? rise_a : rise_b, 0);
            chk(hi_min == lnx && hi_max == lnx, "R5 pulse length", hi_max, lnx);
         end else begin
            logic [1:0] ph;
            ph = 2'(delta);
            chk(trans == mag, "R6 one transition per step", trans, mag);
            chk(simul == 0, "R6 single pin change", simul, 0);
            chk(int_min >= spx + 1, "R6 transition spacing", int_min, spx + 1);
            chk(pin_data == {ph[1] ^ ph[0], ph[1]}, "R6 gray state",
                int'(pin_data), int'({ph[1] ^ ph[0], ph[1]}));
         end
         wr(2'd2, ctrl(0, 1'b0, 2'b00, 2'b00));
      end

      // disabled with a live rate: quiet pins, count held
      c0 = $signed(rd_data);
      wr(2'd1, 32'h0001_0101);
      wr(2'd0, 32'h0000_7000);
      wr(2'd2, ctrl(1, 1'b0, 2'b00, 2'b00));
      repeat (100) @(negedge clk);
      chk(pin_data == 2'b00 && pin_oe == 2'b00, "R2 disabled pins", int'({pin_oe, pin_data}), 0);
      chk($signed(rd_data) == c0, "R10 count held while disabled", $signed(rd_data), c0);

      // enabled, mode off
      wr(2'd2, ctrl(0, 1'b1, 2'b11, 2'b00));
      repeat (100) @(negedge clk);
      chk(pin_data == 2'b00 && pin_own == 2'b00, "R2 mode off pins", int'({pin_own, pin_data}), 0);
      chk($signed(rd_data) == c0, "R2 mode off no steps", $signed(rd_data), c0);

      // active, no motion: ownership and totem-pole drive
      wr(2'd0, 32'd0);
      wr(2'd2, ctrl(1, 1'b1, 2'b00, 2'b00));
      repeat (5) @(negedge clk);
      chk(pin_own == 2'b11, "R7 ownership", int'(pin_own), 3);
      chk(pin_oe == 2'b11 && pin_data == 2'b00, "R9 totem drive", int'({pin_oe, pin_data}), 12);

      // polarity
      wr(2'd2, ctrl(1, 1'b1, 2'b01, 2'b00));
      @(negedge clk);
      chk(pin_data == 2'b01, "R8 invert A", int'(pin_data), 1);
      wr(2'd2, ctrl(1, 1'b1, 2'b11, 2'b00));
      @(negedge clk);
      chk(pin_data == 2'b11, "R8 invert both", int'(pin_data), 3);

      // open collector: released when high, driven when low
      wr(2'd2, ctrl(1, 1'b1, 2'b01, 2'b11));
      @(negedge clk);
      chk(pin_oe == 2'b10, "R9 open collector A released", int'(pin_oe), 2);
      wr(2'd2, ctrl(1, 1'b1, 2'b00, 2'b11));
      @(negedge clk);
      chk(pin_oe == 2'b11, "R9 open collector driven low", int'(pin_oe), 3);

      // quadrature restarts at 00 after disable
      wr(2'd1, 32'h0000_0101);
      wr(2'd0, 32'h0000_6000);
      wr(2'd2, ctrl(3, 1'b1, 2'b00, 2'b00));
      repeat (13) @(negedge clk);
      wr(2'd0, 32'd0);
      repeat (20) @(negedge clk);
      wr(2'd2, ctrl(3, 1'b0, 2'b00, 2'b00));
      wr(2'd2, ctrl(3, 1'b1, 2'b00, 2'b00));
      @(negedge clk);
      chk(pin_data == 2'b00, "R6 restart at 00", int'(pin_data), 0);

      // direct register map check: rate register drives count through write address 0
      c0 = $signed(rd_data);
      wr(2'd2, ctrl(2, 1'b1, 2'b00, 2'b00));
      wr(2'd0, 32'hFFFF_8000);
      repeat (60) @(negedge clk);
      wr(2'd0, 32'd0);
      repeat (30) @(negedge clk);
      chk($signed(rd_data) < c0, "R11 negative rate via address 0", $signed(rd_data), c0 - 1);

      finish_run();
   end

endmodule